// File: doc/BRIEF.md
# Late-Write Synchronous Static RAM

This block is a synchronous static RAM with registers on both its inputs and its output, built for use as a wide cache or buffer store. Each word is 36 bits, split into four 9-bit byte lanes. The array depth is set by an address-width parameter and is kept small for simulation. A write uses late-write timing. The address, command and lane mask are taken on one rising edge, and the data word is taken on the next edge. The write address and data then stay in a pending-write holding stage. They reach the array only when the next write command is accepted.

A read takes its command and address on one edge and delivers the word from the output register after the following edge. On the way, the read address is compared with the held write. On a match, the lanes that the held write enables replace the array contents, so a read always returns the latest written value. The bidirectional data bus is split into `d_in`, `q_out` and a drive strobe `q_drive`. The output enable and the sleep input gate the drive strobe directly, with no clock involved.

The protocol requires one idle cycle between a read and a following write. A registered one-cycle flag reports a write that directly follows a read. That write is still carried out.

Top module: `lw_sram_core`

## Requirements
- R1: After reset, `q_drive` and `turn_err` are 0 and every array word reads as zero.
- R2: A write command is `sel_n`=0, `wr_n`=0 with `sleep` low. The data word on `d_in` is taken on the rising edge after the command.
- R3: `lane_wr_n[i]` (active low) enables lane i, which is bits [9*i+8 : 9*i]. Only the enabled lanes of the word change, and the other lanes keep their old value.
- R4: A write with `lane_wr_n` = 4'b1111 changes no lane of any word.
- R5: A read command is `sel_n`=0, `wr_n`=1. Its word appears on `q_out`, with `q_drive` high when `oe_n` is low, after the second rising edge counted from the command edge.
- R6: A read of the address held by the pending write returns the held data on the enabled lanes and the array contents on the other lanes.
- R7: Back-to-back writes are all kept. When a write is accepted, the previously held write is committed using the data taken on that same edge.
- R8: `q_drive` is high only while `oe_n` is low and a read word is being delivered. A change of `oe_n` takes effect without a clock edge.
- R9: In the delivery slot of a deselect (`sel_n`=1) or write command, `q_drive` is low.
- R10: While `sleep` is high, `q_drive` is low at once and commands are ignored. A command on the first rising edge after `sleep` falls is also ignored.
- R11: When a write command is accepted on the edge right after an accepted read, `turn_err` is high for the cycle after that edge. The write is still performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write command, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| d_in | input | 36 | Write data, taken one edge after the write command |
| oe_n | input | 1 | Output enable, active low, acts without a clock |
| sleep | input | 1 | Sleep request, active high |
| q_out | output | 36 | Read data from the output register |
| q_drive | output | 1 | High when the bus is driven with `q_out` |
| turn_err | output | 1 | One-cycle flag for a write placed directly after a read |

## Verification
The assertions assume that `oe_n` and `sleep` are steady around each rising edge. They also assume that `sleep` stays low on the data edge that follows an accepted write, since the held address otherwise gets data the host never meant to send. The stimulus changes every input on the falling edge. Only the sleep-entry step sets `sleep` during an address phase, and no accepted write is in flight at that point. The output-enable step toggles `oe_n` between edges without clocking, to show the direct path. The bench then restores `oe_n` before the next edge.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  mask_t;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

    typedef struct packed {
        mask_t mask;
        word_t data;
    } lane_word_t;

    function automatic word_t merge_lanes(input word_t base, input lane_word_t upd);
        word_t r;
        for (int i = 0; i < LANES; i++) begin
            r[i*LANE_W +: LANE_W] = upd.mask[i] ? upd.data[i*LANE_W +: LANE_W]
                                                : base[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/lw_cmd_dec.sv
module lw_cmd_dec
    import lw_sram_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_n,
    input  logic wr_n,
    input  logic sleep,
    output cmd_e cmd
);
    logic sleep_q;

    always_ff @(posedge clk) begin
        if (rst) sleep_q <= 1'b0;
        else     sleep_q <= sleep;
    end

    always_comb begin
        if (sleep || sleep_q || sel_n) cmd = CMD_IDLE;
        else if (wr_n)                 cmd = CMD_READ;
        else                           cmd = CMD_WRITE;
    end
endmodule

// File: rtl/lw_pend_wr.sv
module lw_pend_wr
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] addr,
    input  mask_t             lane_wr_n,
    input  word_t             d_in,
    input  logic [ADDR_W-1:0] cmp_addr,
    output logic              commit_en,
    output logic [ADDR_W-1:0] commit_addr,
    output lane_word_t        commit_word,
    output lane_word_t        fwd_word
);
    logic              held_vld;
    logic              data_wait;
    logic [ADDR_W-1:0] held_addr;
    mask_t             held_mask;
    word_t             held_data;
    word_t             eff_data;

    assign eff_data    = data_wait ? d_in : held_data;
    assign commit_en   = (cmd == CMD_WRITE) && held_vld;
    assign commit_addr = held_addr;
    assign commit_word = '{mask: held_mask, data: eff_data};
    assign fwd_word.data = eff_data;
    assign fwd_word.mask = (held_vld && (held_addr == cmp_addr)) ? held_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_vld  <= 1'b0;
            data_wait <= 1'b0;
            held_addr <= '0;
            held_mask <= '0;
            held_data <= '0;
        end else if (cmd == CMD_WRITE) begin
            held_vld  <= 1'b1;
            data_wait <= 1'b1;
            held_addr <= addr;
            held_mask <= ~lane_wr_n;
        end else if (data_wait) begin
            held_data <= d_in;
            data_wait <= 1'b0;
        end
    end
endmodule

// File: rtl/lw_array.sv
module lw_array
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_en,
    input  logic [ADDR_W-1:0] commit_addr,
    input  lane_word_t        commit_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_t             rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int k = 0; k < DEPTH; k++) lane_mem[k] <= '0;
            end else if (commit_en && commit_word.mask[g]) begin
                lane_mem[commit_addr] <= commit_word.data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = lane_mem[rd_addr];
    end
endmodule

// File: rtl/lw_rd_pipe.sv
module lw_rd_pipe
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             arr_data,
    input  lane_word_t        fwd_word,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [ADDR_W-1:0] s1_addr,
    output word_t             q_out,
    output logic              q_drive,
    output logic              turn_err
);
    logic s1_rd;
    logic out_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_rd    <= 1'b0;
            s1_addr  <= '0;
            out_vld  <= 1'b0;
            q_out    <= '0;
            turn_err <= 1'b0;
        end else begin
            s1_rd    <= (cmd == CMD_READ);
            s1_addr  <= addr;
            out_vld  <= s1_rd;
            if (s1_rd) q_out <= merge_lanes(arr_data, fwd_word);
            turn_err <= (cmd == CMD_WRITE) && s1_rd;
        end
    end

    assign q_drive = out_vld && !oe_n && !sleep;
endmodule

// File: rtl/lw_sram_core.sv
module lw_sram_core
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [3:0]        lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [35:0]       d_in,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [35:0]       q_out,
    output logic              q_drive,
    output logic              turn_err
);
    cmd_e              cmd;
    logic              commit_en;
    logic [ADDR_W-1:0] commit_addr;
    lane_word_t        commit_word;
    lane_word_t        fwd_word;
    logic [ADDR_W-1:0] s1_addr;
    word_t             arr_data;

    lw_cmd_dec dec_i (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .sleep(sleep), .cmd(cmd)
    );

    lw_pend_wr #(.ADDR_W(ADDR_W)) pend_i (
        .clk(clk), .rst(rst), .cmd(cmd), .addr(addr), .lane_wr_n(lane_wr_n),
        .d_in(d_in), .cmp_addr(s1_addr), .commit_en(commit_en),
        .commit_addr(commit_addr), .commit_word(commit_word), .fwd_word(fwd_word)
    );

    lw_array #(.ADDR_W(ADDR_W)) arr_i (
        .clk(clk), .rst(rst), .commit_en(commit_en), .commit_addr(commit_addr),
        .commit_word(commit_word), .rd_addr(s1_addr), .rd_data(arr_data)
    );

    lw_rd_pipe #(.ADDR_W(ADDR_W)) pipe_i (
        .clk(clk), .rst(rst), .cmd(cmd), .addr(addr), .arr_data(arr_data),
        .fwd_word(fwd_word), .oe_n(oe_n), .sleep(sleep), .s1_addr(s1_addr),
        .q_out(q_out), .q_drive(q_drive), .turn_err(turn_err)
    );
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk (
    input logic clk,
    input logic rst,
    input logic sel_n,
    input logic wr_n,
    input logic oe_n,
    input logic sleep,
    input logic q_drive,
    input logic turn_err
);
    logic slp_prev;
    logic rd_acc;
    logic wr_acc;

    always_ff @(posedge clk) begin
        if (rst) slp_prev <= 1'b0;
        else     slp_prev <= sleep;
    end

    assign rd_acc = !sel_n &&  wr_n && !sleep && !slp_prev;
    assign wr_acc = !sel_n && !wr_n && !sleep && !slp_prev;

    assert_drive_needs_oe_R8: assert property (@(posedge clk) disable iff (rst)
        q_drive |-> !oe_n);

    assert_sleep_hiz_R10: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !q_drive);

    assert_read_delivers_R5: assert property (@(posedge clk) disable iff (rst)
        rd_acc |=> ##1 (q_drive == (!oe_n && !sleep)));

    assert_write_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        wr_acc |=> ##1 !q_drive);

    assert_turn_flag_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_acc ##1 wr_acc) |=> turn_err);

    assert_flag_cause_R11: assert property (@(posedge clk) disable iff (rst)
        turn_err |-> ($past(wr_acc) && $past(rd_acc, 2)));
endmodule

bind lw_sram_core lw_sram_chk chk_i (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
    .sleep(sleep), .q_drive(q_drive), .turn_err(turn_err)
);

// File: tb/lw_sram_core_tb_top.sv
`timescale 1ns/1ps
module lw_sram_core_tb_top;
    localparam int AW = 6;

    typedef struct packed {
        logic        sel_n;
        logic        wr_n;
        logic [3:0]  ben;
        logic [5:0]  addr;
        logic [35:0] din;
        logic        oe_n;
        logic        chk;
        logic        e_drv;
        logic [35:0] e_q;
    } vec_t;

    localparam logic [35:0] D1 = {9'h111, 9'h122, 9'h133, 9'h144};
    localparam logic [35:0] DF = {4{9'h1FF}};
    localparam logic [35:0] M1 = {9'h111, 9'h1FF, 9'h133, 9'h1FF};
    localparam logic [35:0] DA = {9'h0A1, 9'h0A2, 9'h0A3, 9'h0A4};
    localparam logic [35:0] DB = {9'h0B1, 9'h0B2, 9'h0B3, 9'h0B4};
    localparam logic [35:0] DC = {9'h0C1, 9'h0C2, 9'h0C3, 9'h0C4};
    localparam logic [35:0] Z  = 36'h0;

    localparam int NV = 22;
    // sel_n wr_n ben addr din oe_n chk e_drv e_q
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 4'h0, 6'd5, Z,  1'b0, 1'b1, 1'b0, Z },  // R9 write slot quiet
        '{1'b1, 1'b1, 4'h0, 6'd0, D1, 1'b0, 1'b1, 1'b0, Z },  // R2 data phase
        '{1'b0, 1'b1, 4'h0, 6'd5, Z,  1'b0, 1'b0, 1'b0, Z },
        '{1'b1, 1'b1, 4'h0, 6'd0, Z,  1'b0, 1'b1, 1'b1, D1},  // R5 R6 full forward
        '{1'b0, 1'b0, 4'hA, 6'd5, Z,  1'b0, 1'b1, 1'b0, Z },  // R3 lanes 0,2
        '{1'b1, 1'b1, 4'h0, 6'd0, DF, 1'b0, 1'b0, 1'b0, Z },
        '{1'b0, 1'b1, 4'h0, 6'd5, Z,  1'b0, 1'b0, 1'b0, Z },
        '{1'b1, 1'b1, 4'h0, 6'd0, Z,  1'b0, 1'b1, 1'b1, M1},  // R3 R6 lane merge
        '{1'b0, 1'b0, 4'hF, 6'd5, Z,  1'b0, 1'b0, 1'b0, Z },  // R4 abort
        '{1'b1, 1'b1, 4'h0, 6'd0, DC, 1'b0, 1'b0, 1'b0, Z },
        '{1'b0, 1'b1, 4'h0, 6'd5, Z,  1'b0, 1'b0, 1'b0, Z },
        '{1'b1, 1'b1, 4'h0, 6'd0, Z,  1'b0, 1'b1, 1'b1, M1},  // R4 unchanged
        '{1'b0, 1'b1, 4'h0, 6'd9, Z,  1'b0, 1'b1, 1'b0, Z },  // R9 deselect slot
        '{1'b1, 1'b1, 4'h0, 6'd0, Z,  1'b0, 1'b1, 1'b1, Z },  // R1 zeroed word
        '{1'b0, 1'b1, 4'h0, 6'd5, Z,  1'b1, 1'b0, 1'b0, Z },
        '{1'b1, 1'b1, 4'h0, 6'd0, Z,  1'b1, 1'b1, 1'b0, Z },  // R8 oe high
        '{1'b0, 1'b0, 4'h0, 6'd1, Z,  1'b0, 1'b0, 1'b0, Z },
        '{1'b0, 1'b0, 4'h0, 6'd2, DA, 1'b0, 1'b0, 1'b0, Z },  // R7 back to back
        '{1'b1, 1'b1, 4'h0, 6'd0, DB, 1'b0, 1'b0, 1'b0, Z },
        '{1'b0, 1'b1, 4'h0, 6'd1, Z,  1'b0, 1'b0, 1'b0, Z },
        '{1'b0, 1'b1, 4'h0, 6'd2, Z,  1'b0, 1'b1, 1'b1, DA},  // R7 committed word
        '{1'b1, 1'b1, 4'h0, 6'd0, Z,  1'b0, 1'b1, 1'b1, DB}   // R6 R7 held word
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_n = 1'b1, wr_n = 1'b1, oe_n = 1'b0, sleep = 1'b0;
    logic [3:0]    lane_wr_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic [35:0]   d_in = '0;
    logic [35:0]   q_out;
    logic          q_drive, turn_err;
    int            total = 0, bad = 0;
    logic          done = 1'b0;

    always #10 clk = ~clk;

    lw_sram_core #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
        .addr(addr), .d_in(d_in), .oe_n(oe_n), .sleep(sleep),
        .q_out(q_out), .q_drive(q_drive), .turn_err(turn_err)
    );

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic s, input logic w, input logic [3:0] b,
                       input logic [AW-1:0] a, input logic [35:0] d);
        sel_n = s; wr_n = w; lane_wr_n = b; addr = a; d_in = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset drive", {35'd0, q_drive}, 36'd0);
        check("R1 reset flag", {35'd0, turn_err}, 36'd0);

        for (int i = 0; i < NV; i++) begin
            oe_n = VEC[i].oe_n;
            cyc(VEC[i].sel_n, VEC[i].wr_n, VEC[i].ben, VEC[i].addr, VEC[i].din);
            if (VEC[i].chk) begin
                check($sformatf("R5 R8 R9 vector %0d drive", i), {35'd0, q_drive}, {35'd0, VEC[i].e_drv});
                if (VEC[i].e_drv)
                    check($sformatf("R2 R3 R4 R6 R7 vector %0d data", i), q_out, VEC[i].e_q);
                check($sformatf("R11 vector %0d flag", i), {35'd0, turn_err}, 36'd0);
            end
        end

        // R8: output enable acts with no clock edge
        cyc(1'b0, 1'b1, 4'h0, 6'd1, Z);
        cyc(1'b1, 1'b1, 4'h0, 6'd0, Z);
        check("R8 delivered word", q_out, DA);
        #2 oe_n = 1'b1;
        #1 check("R8 oe high async", {35'd0, q_drive}, 36'd0);
        oe_n = 1'b0;
        #1 check("R8 oe low async", {35'd0, q_drive}, 36'd1);

        // R10: sleep drops drive at once and blocks commands
        sleep = 1'b1;
        #1 check("R10 sleep hiz", {35'd0, q_drive}, 36'd0);
        @(negedge clk);
        cyc(1'b0, 1'b0, 4'h0, 6'd1, Z);
        cyc(1'b1, 1'b1, 4'h0, 6'd0, DC);
        sleep = 1'b0;
        cyc(1'b0, 1'b0, 4'h0, 6'd1, Z);   // first edge after release: ignored
        cyc(1'b1, 1'b1, 4'h0, 6'd0, DC);
        cyc(1'b0, 1'b1, 4'h0, 6'd1, Z);
        cyc(1'b1, 1'b1, 4'h0, 6'd0, Z);
        check("R10 word untouched", q_out, DA);
        check("R10 drive restored", {35'd0, q_drive}, 36'd1);

        // R11: write directly after read raises the flag and still writes
        cyc(1'b0, 1'b1, 4'h0, 6'd2, Z);
        cyc(1'b0, 1'b0, 4'h0, 6'd3, Z);
        check("R11 flag set", {35'd0, turn_err}, 36'd1);
        cyc(1'b1, 1'b1, 4'h0, 6'd0, DC);
        check("R11 flag clears", {35'd0, turn_err}, 36'd0);
        cyc(1'b0, 1'b1, 4'h0, 6'd3, Z);
        cyc(1'b1, 1'b1, 4'h0, 6'd0, Z);
        check("R11 write performed", q_out, DC);

        // R1: reset clears the array and outputs
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 drive after reset", {35'd0, q_drive}, 36'd0);
        cyc(1'b0, 1'b1, 4'h0, 6'd1, Z);
        cyc(1'b1, 1'b1, 4'h0, 6'd0, Z);
        check("R1 array cleared", q_out, Z);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule